// File: doc/BRIEF.md
# RMII Transmit Di-bit Serializer

This block sits on the MAC side of a Reduced Media Independent Interface running at 100 Mb/s. It accepts frame bytes from a byte stream that has valid, ready and a final-byte marker. It turns each frame into the two-bit transmit bus plus its enable, timed on the single 50 MHz reference clock. The caller supplies a complete frame, checksum included. Before the first payload byte the block adds a preamble of seven 0x55 bytes and a 0xD5 start-of-frame delimiter. Each byte goes out as four di-bits, and the block enforces the quiet time between frames.

A frame starts when the stream shows valid while the block is idle and the gap since the previous frame has run out. The block pulls a byte only during the last di-bit of the byte on the wire, so it takes at most one byte every four clocks. If no byte is offered at that moment, the frame is cut short and a one-clock underrun flag is raised. The block never pads a frame with idle di-bits.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is held and in the first clock after it, tx_en is 0, txd is 00, in_ready is 0 and underrun is 0.
- R2: From idle with the gap satisfied, in_valid seen at a clock edge makes tx_en go high on that edge, and txd carries 01 in the same clock.
- R3: The first 32 di-bits of every frame are 31 copies of 01 followed by 11. These are seven 0x55 bytes and then 0xD5, each sent low pair first.
- R4: Each payload byte is sent as four consecutive di-bits in the order bits [1:0], [3:2], [5:4], [7:6].
- R5: tx_en stays high without a gap for the whole frame and is low in the clock right after the final di-bit. A complete frame of N bytes therefore holds tx_en high for exactly 32+4N clocks.
- R6: txd is 00 in every clock where tx_en is low.
- R7: in_ready is high only while tx_en is high, and only in the clock that carries the fourth di-bit of the delimiter or of a payload byte not marked last. A byte is taken at a rising edge where in_valid and in_ready are both high.
- R8: After tx_en falls it stays low for at least IFG_CLKS (default 48) clocks. If the next frame is already waiting, it stays low for exactly that many.
- R9: If in_valid is low in a clock where in_ready is high, tx_en and txd go to 0 in the next clock and underrun is high for exactly that one clock. The frame holds only the bytes accepted before that point.
- R10: underrun is 0 in every clock except the one named in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte taken at this edge when in_valid is high |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 2 | Transmit di-bit toward the PHY |
| underrun | output | 1 | One-clock pulse when a frame is cut short |

## Verification
Every output is a register, so each result shows up one clock after the edge that decides it. tx_en and the first preamble di-bit appear one clock after in_valid is first seen. A taken byte's low pair appears one clock after the handshake edge. The drop of tx_en and the underrun pulse land one clock after the last di-bit or after the starved ready clock. The bench drives inputs and samples outputs on the falling edge. It keeps a per-frame position counter, so each di-bit, ready slot and frame length is compared at the exact clock when it is due. Gaps are counted as idle clocks between falling and rising tx_en, and must equal 48 when the next frame is waiting.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_PRE   = 2'd1,
    TX_DATA  = 2'd2
  } tx_state_t;

  localparam logic [7:0] PRE_PATTERN = 8'h55;
  localparam logic [7:0] SFD_PATTERN = 8'hD5;

endpackage

// File: rtl/rmii_tx_gap_timer.sv
module rmii_tx_gap_timer #(
  parameter int IFG_CLKS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  output logic gap_done
);

  localparam int CW = $clog2(IFG_CLKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(IFG_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (frame_end) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign gap_done = (cnt_q == '0);

endmodule

// File: rtl/rmii_tx_dibit_shifter.sv
module rmii_tx_dibit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift,
  input  logic              clear,
  output logic [1:0]        txd
);

  logic [BYTE_W-1:0] sh_q;
  logic [1:0]        txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      txd_q <= 2'b00;
    end else if (clear) begin
      sh_q  <= '0;
      txd_q <= 2'b00;
    end else if (load) begin
      txd_q <= load_byte[1:0];
      sh_q  <= load_byte >> 2;
    end else if (shift) begin
      txd_q <= sh_q[1:0];
      sh_q  <= sh_q >> 2;
    end
  end

  assign txd = txd_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> txd_q == 2'b00); // R6
  AST_FIRST_DIBIT: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> txd_q == 2'b01); // R2

endmodule

// File: rtl/rmii_tx_seq.sv
module rmii_tx_seq
  import rmii_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_BYTES = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              gap_done,
  output logic              in_ready,
  output logic              tx_en,
  output logic              underrun,
  output logic              frame_end,
  output logic              sh_load,
  output logic [BYTE_W-1:0] sh_byte,
  output logic              sh_shift,
  output logic              sh_clear
);

  localparam int DIBITS = BYTE_W / 2;
  localparam int DW     = $clog2(DIBITS);
  localparam int PW     = $clog2(PRE_BYTES + 1);
  localparam logic [DW-1:0] DIB_MAX  = DW'(DIBITS - 1);
  localparam logic [DW-1:0] DIB_PREV = DW'(DIBITS - 2);
  localparam logic [PW-1:0] PRE_SFD  = PW'(PRE_BYTES);
  localparam logic [PW-1:0] PRE_END  = PW'(PRE_BYTES - 1);

  tx_state_t     state_q;
  logic [DW-1:0] dib_q;
  logic [PW-1:0] pre_q;
  logic          last_q;
  logic          en_q;
  logic          rdy_q;
  logic          ur_q;

  logic dib_last, start, pre_next, accept, starve, done_last, wants_byte, rdy_next;

  always_comb begin
    dib_last   = (dib_q == DIB_MAX);
    start      = (state_q == TX_IDLE) && in_valid && gap_done;
    pre_next   = (state_q == TX_PRE) && dib_last && (pre_q != PRE_SFD);
    accept     = rdy_q && in_valid;
    starve     = rdy_q && !in_valid;
    done_last  = (state_q == TX_DATA) && dib_last && last_q;
    wants_byte = ((state_q == TX_PRE) && (pre_q == PRE_SFD)) ||
                 ((state_q == TX_DATA) && !last_q);
    rdy_next   = wants_byte && (dib_q == DIB_PREV);
  end

  always_comb begin
    sh_load  = start || pre_next || accept;
    sh_shift = en_q && !dib_last;
    sh_clear = starve || done_last;
    if (start) begin
      sh_byte = BYTE_W'(PRE_PATTERN);
    end else if (pre_next) begin
      sh_byte = (pre_q == PRE_END) ? BYTE_W'(SFD_PATTERN) : BYTE_W'(PRE_PATTERN);
    end else begin
      sh_byte = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      dib_q   <= '0;
      pre_q   <= '0;
      last_q  <= 1'b0;
      en_q    <= 1'b0;
      rdy_q   <= 1'b0;
      ur_q    <= 1'b0;
    end else begin
      rdy_q <= rdy_next;
      ur_q  <= starve;
      case (state_q)
        TX_IDLE: begin
          if (start) begin
            state_q <= TX_PRE;
            en_q    <= 1'b1;
            dib_q   <= '0;
            pre_q   <= '0;
            last_q  <= 1'b0;
          end
        end
        TX_PRE: begin
          if (!dib_last) begin
            dib_q <= dib_q + 1'b1;
          end else if (pre_next) begin
            pre_q <= pre_q + 1'b1;
            dib_q <= '0;
          end else if (accept) begin
            state_q <= TX_DATA;
            dib_q   <= '0;
            last_q  <= in_last;
          end else begin
            state_q <= TX_IDLE;
            en_q    <= 1'b0;
          end
        end
        TX_DATA: begin
          if (!dib_last) begin
            dib_q <= dib_q + 1'b1;
          end else if (last_q) begin
            state_q <= TX_IDLE;
            en_q    <= 1'b0;
          end else if (accept) begin
            dib_q  <= '0;
            last_q <= in_last;
          end else begin
            state_q <= TX_IDLE;
            en_q    <= 1'b0;
          end
        end
        default: begin
          state_q <= TX_IDLE;
          en_q    <= 1'b0;
        end
      endcase
    end
  end

  assign in_ready  = rdy_q;
  assign tx_en     = en_q;
  assign underrun  = ur_q;
  assign frame_end = sh_clear;

  AST_READY_SLOT: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> en_q && dib_q == DIB_MAX); // R7
  AST_UNDERRUN_EDGE: assert property (@(posedge clk) disable iff (rst)
    ur_q |-> !en_q && $past(en_q)); // R9
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    ur_q |=> !ur_q); // R10
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> dib_q == '0 && pre_q == '0); // R2

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int BYTE_W    = 8,
  parameter int PRE_BYTES = 7,
  parameter int IFG_CLKS  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_en,
  output logic [1:0]        txd,
  output logic              underrun
);

  logic              gap_done;
  logic              frame_end;
  logic              sh_load;
  logic [BYTE_W-1:0] sh_byte;
  logic              sh_shift;
  logic              sh_clear;

  rmii_tx_seq #(
    .BYTE_W    (BYTE_W),
    .PRE_BYTES (PRE_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .gap_done  (gap_done),
    .in_ready  (in_ready),
    .tx_en     (tx_en),
    .underrun  (underrun),
    .frame_end (frame_end),
    .sh_load   (sh_load),
    .sh_byte   (sh_byte),
    .sh_shift  (sh_shift),
    .sh_clear  (sh_clear)
  );

  rmii_tx_dibit_shifter #(
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .load      (sh_load),
    .load_byte (sh_byte),
    .shift     (sh_shift),
    .clear     (sh_clear),
    .txd       (txd)
  );

  rmii_tx_gap_timer #(
    .IFG_CLKS (IFG_CLKS)
  ) u_gap (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .gap_done  (gap_done)
  );

  AST_GAP_RESPECT: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(gap_done)); // R8
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_en); // R7

endmodule

// File: tb/rmii_tx_serializer_bench.sv
module rmii_tx_serializer_bench;

  localparam int CLK_PERIOD = 20;
  localparam int NF         = 12;
  localparam int GAP        = 48;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, tx_en, underrun;
  logic [1:0] txd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int first_valid_cyc = -1;
  bit finished = 1'b0;

  rmii_tx_serializer u_rmii_tx_serializer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .tx_en(tx_en), .txd(txd),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int flen(int f);
    if (f < 8) return f + 1;
    if (f == 8) return 20;
    if (f == 9) return 5;
    if (f == 10) return 3;
    return 2;
  endfunction

  function automatic int fstall(int f);
    if (f == 9) return 2;
    if (f == 10) return 0;
    return -1;
  endfunction

  function automatic logic [7:0] fbyte(int f, int i);
    return 8'((f * 37 + i * 13 + 5) & 255);
  endfunction

  function automatic int nsent(int f);
    return (fstall(f) >= 0) ? fstall(f) : flen(f);
  endfunction

  function automatic int nslots(int f);
    return (fstall(f) >= 0) ? fstall(f) + 1 : flen(f);
  endfunction

  function automatic logic [1:0] exp_dibit(int f, int p);
    logic [7:0] b;
    if (p < 31) return 2'b01;
    if (p == 31) return 2'b11;
    b = fbyte(f, (p - 32) / 4);
    return 2'((b >> (2 * ((p - 32) % 4))) & 8'h3);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor
  bit prev_en = 1'b0;
  int pos = 0;
  int fid = 0;
  int low_cnt = 0;
  bit mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_rdy;
      if (!tx_en) check(txd == 2'b00, "R6 idle txd", int'(txd), 0);
      if (prev_en && !tx_en) begin
        check(pos == 32 + 4 * nsent(fid), "R5 frame length", pos, 32 + 4 * nsent(fid));
        check(underrun == (fstall(fid) >= 0), "R9 underrun at end", int'(underrun),
              int'(fstall(fid) >= 0));
        fid++;
        low_cnt = 1;
      end else begin
        check(underrun == 1'b0, "R10 underrun quiet", int'(underrun), 0);
        if (!tx_en) low_cnt++;
      end
      if (tx_en) begin
        if (!prev_en) begin
          pos = 0;
          if (fid == 0)
            check(cyc == first_valid_cyc + 1, "R2 start latency", cyc, first_valid_cyc + 1);
          else
            check(low_cnt == GAP, "R8 gap", low_cnt, GAP);
        end
        if (fid < NF) begin
          if (pos < 32)
            check(txd == exp_dibit(fid, pos), "R3 preamble dibit", int'(txd),
                  int'(exp_dibit(fid, pos)));
          else
            check(txd == exp_dibit(fid, pos), "R4 payload dibit", int'(txd),
                  int'(exp_dibit(fid, pos)));
          exp_rdy = (pos >= 31) && ((pos - 31) % 4 == 0) && ((pos - 31) / 4 < nslots(fid));
          check(in_ready == exp_rdy, "R7 ready slot", int'(in_ready), int'(exp_rdy));
        end
        pos++;
      end else begin
        check(in_ready == 1'b0, "R7 ready idle", int'(in_ready), 0);
      end
      prev_en = tx_en;
    end
  end

  // driver
  initial begin
    int f, idx;
    bit hs, dropped;
    repeat (3) @(negedge clk);
    check(tx_en == 1'b0, "R1 reset tx_en", int'(tx_en), 0);
    check(txd == 2'b00, "R1 reset txd", int'(txd), 0);
    check(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
    check(underrun == 1'b0, "R1 reset underrun", int'(underrun), 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_en == 1'b0 && txd == 2'b00, "R1 after reset", int'(tx_en), 0);
    mon_on = 1'b1;
    f = 0; idx = 0; hs = 1'b0; dropped = 1'b0;
    while (f < NF) begin
      if (hs) idx++;
      if (fstall(f) < 0 && idx == flen(f)) begin
        f++; idx = 0;
      end else if (fstall(f) >= 0 && underrun) begin
        f++; idx = 0; dropped = 1'b0;
      end else if (fstall(f) >= 0 && idx == fstall(f) && tx_en) begin
        dropped = 1'b1;
      end
      if (f < NF) begin
        in_valid = !dropped;
        in_data  = fbyte(f, idx);
        in_last  = (fstall(f) < 0) && (idx == flen(f) - 1);
        if (first_valid_cyc < 0) first_valid_cyc = cyc;
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      hs = in_valid && in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (80) @(negedge clk);
    check(fid == NF, "R5 frames emitted", fid, NF);
    check(tx_en == 1'b0, "R8 quiet after last", int'(tx_en), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule